// File: doc/BRIEF.md
# Rotating-Parity Three-Disk Stripe Mapper

This block sits between a stream of logical data words and three disk ports. On the write side it collects logical words two at a time. Each pair forms one stripe. The block computes the XOR of the two words and writes all three disks in a single cycle. Which disk holds the parity word changes from stripe to stripe in a fixed three-stripe cycle. The two data words also swap disks along that cycle, so no single disk takes every parity update.

On the read side the block turns a logical word index into a stripe index and a slot. It then picks the disk that holds that word and returns the word two cycles after the request. One disk may be marked as failed. A read aimed at the failed disk fetches the two surviving disks of the stripe and returns their XOR, one cycle later than a normal read. Reads aimed at a surviving disk are not affected. If a second, different disk is marked as failed, data can no longer be recovered. The block then raises a sticky error, refuses writes and answers every read with an error status.

Top module: `raid5_stripe_map`

## Requirements
- R1: After reset `wr_ready`=1, `rd_ready`=1, `rd_valid`=0, `dsk_wr_en`=0, `dsk_rd_en`=0 and `array_err`=0.
- R2: A stripe is written only when its second word is accepted. In the cycle after that acceptance `dsk_wr_en`=1 for exactly one cycle, with `dsk_wr_addr` equal to the stripe number (0 for the first stripe after reset, then counting up). Accepting the first word of a pair leaves `dsk_wr_en`=0.
- R3: In every stripe write, the parity word equals the XOR of the stripe's two data words, so the three disk words XOR to zero.
- R4: Let the stripe number s have phase p = s mod 3, let A be the earlier word of the pair and B the later one. For p=0: disk0=A, disk1=B, disk2=parity. For p=1: disk0=A, disk1=parity, disk2=B. For p=2: disk0=parity, disk1=B, disk2=A. After stripe 65535 the count wraps to 0 and the phase restarts at 0.
- R5: A read of logical word k (`rd_addr`=k) targets stripe k>>1 and slot k&1. Slot 0 is word A and slot 1 is word B, placed by the mapping of R4. With no disk failed, exactly one bit of `dsk_rd_en` is set (bit i selects disk i), in the request cycle, with `dsk_rd_addr`=k>>1. The stored word appears on `rd_data` with `rd_valid`=1 and `rd_err`=0 two cycles after the request cycle.
- R6: While one disk f is marked failed, a read whose target disk is f sets the two other `dsk_rd_en` bits and returns their XOR three cycles after the request. A read whose target disk survives behaves as in R5.
- R7: In the cycle after a reconstructing request is accepted, `rd_ready`=0, so no new read is accepted then.
- R8: A pulse on `fail_valid` with `fail_id` in 0..2 marks that disk as failed when none is marked. The value 3 is ignored, and repeating the id already marked changes nothing.
- R9: A `fail_valid` pulse naming a second, different disk sets `array_err` from the next cycle until reset. While `array_err`=1: `wr_ready`=0, no `dsk_rd_en` bit is set, and every read returns `rd_valid`=1, `rd_err`=1 and `rd_data`=0 two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Logical write word offered |
| wr_data | input | W | Logical write word |
| wr_ready | output | 1 | Write word accepted when high together with wr_valid |
| dsk_wr_en | output | 1 | Write strobe to all three disks |
| dsk_wr_addr | output | SW | Stripe number being written |
| dsk_wr_d0 | output | W | Word for disk 0 |
| dsk_wr_d1 | output | W | Word for disk 1 |
| dsk_wr_d2 | output | W | Word for disk 2 |
| rd_req | input | 1 | Read request |
| rd_addr | input | SW+1 | Logical word index to read |
| rd_ready | output | 1 | Read request accepted when high together with rd_req |
| dsk_rd_en | output | 3 | Per-disk read enable, bit i for disk i |
| dsk_rd_addr | output | SW | Stripe number being read |
| dsk_rd_q0 | input | W | Disk 0 read data, valid the cycle after its enable |
| dsk_rd_q1 | input | W | Disk 1 read data, valid the cycle after its enable |
| dsk_rd_q2 | input | W | Disk 2 read data, valid the cycle after its enable |
| rd_valid | output | 1 | Read result present |
| rd_data | output | W | Read result word |
| rd_err | output | 1 | Read result is an error (unrecoverable array) |
| fail_valid | input | 1 | Failure report strobe |
| fail_id | input | 2 | Disk being reported failed (3 = no disk) |
| array_err | output | 1 | Two different disks have been reported failed |

## Verification
The assertions take for granted that each disk returns the word for an enabled read exactly one cycle after the enable. They also take for granted that `rd_req` and `wr_valid` are driven as clean levels, free of X, once reset is released. The latency property counts on this fixed disk delay to hold reads to two or three cycles. The stimulus keeps to these assumptions. A bench disk model answers every enable after one register stage, and a failed disk returns a junk pattern, so reconstruction must really come from the two survivors. Requests wait for `rd_ready` before they are issued, and all inputs change only on the falling edge.

// File: rtl/r5_pkg.sv
package r5_pkg;

  localparam int unsigned NDISK = 3;

  // Stripe number modulo 3: 4 = 1 (mod 3), so sum the base-4 digits.
  function automatic logic [1:0] phase_of(input logic [31:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 16; i++) begin
      r = r + {1'b0, v[2*i +: 2]};
      if (r >= 3'd3) r = r - 3'd3;
    end
    return r[1:0];
  endfunction

  // Disk that holds a data slot (0 = earlier word, 1 = later word).
  function automatic logic [1:0] slot_disk(input logic [1:0] ph, input logic slot);
    case (ph)
      2'd0:    return slot ? 2'd1 : 2'd0;
      2'd1:    return slot ? 2'd2 : 2'd0;
      default: return slot ? 2'd1 : 2'd2;
    endcase
  endfunction

  // Role of a disk in a stripe: 0 = earlier word, 1 = later word, 2 = parity.
  function automatic logic [1:0] disk_role(input logic [1:0] ph, input logic [1:0] dsk);
    logic [1:0] par;
    par = 2'd2 - ph;
    if (dsk == par) return 2'd2;
    if (dsk == slot_disk(ph, 1'b0)) return 2'd0;
    return 2'd1;
  endfunction

endpackage

// File: rtl/r5_stripe_writer.sv
module r5_stripe_writer
  import r5_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [W-1:0]             wr_data,
  input  logic                     blocked,
  output logic                     wr_ready,
  output logic                     dsk_wr_en,
  output logic [SW-1:0]            dsk_wr_addr,
  output logic [NDISK-1:0][W-1:0]  dsk_wr_d,
  output logic [SW-1:0]            stripe_cnt,
  output logic [1:0]               phase
);
  localparam logic [SW-1:0] CNT_LAST = {SW{1'b1}};

  logic         have_first;
  logic [W-1:0] first_q;
  logic         take;
  logic         pair_done;

  assign wr_ready  = !blocked;
  assign take      = wr_valid && wr_ready;
  assign pair_done = take && have_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_first  <= 1'b0;
      first_q     <= '0;
      dsk_wr_en   <= 1'b0;
      dsk_wr_addr <= '0;
      stripe_cnt  <= '0;
      phase       <= 2'd0;
    end else begin
      dsk_wr_en <= pair_done;
      if (take && !have_first) begin
        first_q    <= wr_data;
        have_first <= 1'b1;
      end
      if (pair_done) begin
        have_first  <= 1'b0;
        dsk_wr_addr <= stripe_cnt;
        stripe_cnt  <= stripe_cnt + 1'b1;
        if (stripe_cnt == CNT_LAST || phase == 2'd2) phase <= 2'd0;
        else                                         phase <= phase + 2'd1;
      end
    end
  end

  for (genvar d = 0; d < NDISK; d++) begin : g_disk
    logic [1:0] role;
    assign role = disk_role(phase, d[1:0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dsk_wr_d[d] <= '0;
      end else if (pair_done) begin
        case (role)
          2'd0:    dsk_wr_d[d] <= first_q;
          2'd1:    dsk_wr_d[d] <= wr_data;
          default: dsk_wr_d[d] <= first_q ^ wr_data;
        endcase
      end
    end
  end

endmodule

// File: rtl/r5_fail_track.sv
module r5_fail_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_valid,
  input  logic [1:0] fail_id,
  output logic       failed_vld,
  output logic [1:0] failed_id,
  output logic       array_err
);
  logic report;
  assign report = fail_valid && (fail_id != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      failed_vld <= 1'b0;
      failed_id  <= 2'd0;
      array_err  <= 1'b0;
    end else if (report) begin
      if (!failed_vld) begin
        failed_vld <= 1'b1;
        failed_id  <= fail_id;
      end else if (fail_id != failed_id) begin
        array_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/r5_read_path.sv
module r5_read_path
  import r5_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req,
  input  logic [SW:0]              rd_addr,
  input  logic                     failed_vld,
  input  logic [1:0]               failed_id,
  input  logic                     array_err,
  input  logic [NDISK-1:0][W-1:0]  dsk_q,
  output logic                     rd_ready,
  output logic [NDISK-1:0]         dsk_rd_en,
  output logic [SW-1:0]            dsk_rd_addr,
  output logic                     rd_valid,
  output logic [W-1:0]             rd_data,
  output logic                     rd_err
);
  logic [SW-1:0] stripe;
  logic [1:0]    ph;
  logic [1:0]    tgt;
  logic          fire;
  logic          recon;
  logic [NDISK-1:0] tgt_bit;

  logic          s1_vld, s1_recon, s1_err;
  logic [1:0]    s1_tgt;
  logic          s2_vld;
  logic [W-1:0]  s2_data;
  logic [W-1:0]  survivors;

  assign stripe      = rd_addr[SW:1];
  assign ph          = phase_of(32'(stripe));
  assign tgt         = slot_disk(ph, rd_addr[0]);
  assign tgt_bit     = 3'b001 << tgt;
  assign rd_ready    = !s1_recon;
  assign fire        = rd_req && rd_ready;
  assign recon       = failed_vld && (failed_id == tgt) && !array_err;
  assign dsk_rd_addr = stripe;

  always_comb begin
    dsk_rd_en = '0;
    if (fire && !array_err) dsk_rd_en = recon ? ~tgt_bit : tgt_bit;
  end

  always_comb begin
    survivors = '0;
    for (int d = 0; d < NDISK; d++)
      if (d[1:0] != s1_tgt) survivors = survivors ^ dsk_q[d];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_recon <= 1'b0;
      s1_err   <= 1'b0;
      s1_tgt   <= 2'd0;
      s2_vld   <= 1'b0;
      s2_data  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      s1_vld   <= fire;
      s1_recon <= fire && recon;
      s1_err   <= fire && array_err;
      s1_tgt   <= tgt;
      s2_vld   <= s1_vld && s1_recon;
      s2_data  <= survivors;
      if (s1_vld && !s1_recon) begin
        rd_valid <= 1'b1;
        rd_err   <= s1_err;
        rd_data  <= s1_err ? '0 : dsk_q[s1_tgt];
      end else if (s2_vld) begin
        rd_valid <= 1'b1;
        rd_err   <= 1'b0;
        rd_data  <= s2_data;
      end else begin
        rd_valid <= 1'b0;
        rd_err   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/raid5_stripe_map.sv
module raid5_stripe_map
  import r5_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  output logic          wr_ready,
  output logic          dsk_wr_en,
  output logic [SW-1:0] dsk_wr_addr,
  output logic [W-1:0]  dsk_wr_d0,
  output logic [W-1:0]  dsk_wr_d1,
  output logic [W-1:0]  dsk_wr_d2,
  input  logic          rd_req,
  input  logic [SW:0]   rd_addr,
  output logic          rd_ready,
  output logic [2:0]    dsk_rd_en,
  output logic [SW-1:0] dsk_rd_addr,
  input  logic [W-1:0]  dsk_rd_q0,
  input  logic [W-1:0]  dsk_rd_q1,
  input  logic [W-1:0]  dsk_rd_q2,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          rd_err,
  input  logic          fail_valid,
  input  logic [1:0]    fail_id,
  output logic          array_err
);
  logic [NDISK-1:0][W-1:0] wr_bus;
  logic [NDISK-1:0][W-1:0] rd_bus;
  logic [SW-1:0]           wr_cnt;
  logic [1:0]              wr_phase;
  logic                    failed_vld;
  logic [1:0]              failed_id;

  assign dsk_wr_d0 = wr_bus[0];
  assign dsk_wr_d1 = wr_bus[1];
  assign dsk_wr_d2 = wr_bus[2];
  assign rd_bus    = {dsk_rd_q2, dsk_rd_q1, dsk_rd_q0};

  r5_stripe_writer #(.W(W), .SW(SW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .blocked    (array_err),
    .wr_ready   (wr_ready),
    .dsk_wr_en  (dsk_wr_en),
    .dsk_wr_addr(dsk_wr_addr),
    .dsk_wr_d   (wr_bus),
    .stripe_cnt (wr_cnt),
    .phase      (wr_phase)
  );

  r5_fail_track u_fail (
    .clk       (clk),
    .rst_n     (rst_n),
    .fail_valid(fail_valid),
    .fail_id   (fail_id),
    .failed_vld(failed_vld),
    .failed_id (failed_id),
    .array_err (array_err)
  );

  r5_read_path #(.W(W), .SW(SW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .failed_vld (failed_vld),
    .failed_id  (failed_id),
    .array_err  (array_err),
    .dsk_q      (rd_bus),
    .rd_ready   (rd_ready),
    .dsk_rd_en  (dsk_rd_en),
    .dsk_rd_addr(dsk_rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_err     (rd_err)
  );

endmodule

// File: rtl/r5_checker.sv
module r5_checker
  import r5_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          dsk_wr_en,
  input logic [W-1:0]  dsk_wr_d0,
  input logic [W-1:0]  dsk_wr_d1,
  input logic [W-1:0]  dsk_wr_d2,
  input logic          rd_req,
  input logic          rd_ready,
  input logic [2:0]    dsk_rd_en,
  input logic          rd_valid,
  input logic          array_err,
  input logic [SW-1:0] wr_cnt,
  input logic [1:0]    wr_phase
);
  // R2: a stripe write always follows an accepted word
  a_r2_write_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_wr_en |-> $past(wr_valid && wr_ready));

  // R3: the three disk words of a stripe cancel out
  a_r3_parity_closes: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_wr_en |-> ((dsk_wr_d0 ^ dsk_wr_d1 ^ dsk_wr_d2) == '0));

  // R4: running phase agrees with the stripe count
  a_r4_phase_sync: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase == phase_of(32'(wr_cnt)));

  // R5: disk reads only for an accepted request, at most two disks
  a_r5_enable_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_rd_en != 3'b000) |-> (rd_req && rd_ready && $countones(dsk_rd_en) <= 2));

  // R5/R6: a result comes two or three cycles after an accepted request
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_req && rd_ready, 2) || $past(rd_req && rd_ready, 3)));

  // R7: a reconstructing fetch is followed by a bubble
  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dsk_rd_en) == 2) |=> !rd_ready);

  // R9: the double-failure error is sticky and blocks writes
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    array_err |=> array_err);

  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    array_err |-> (!wr_ready && dsk_rd_en == 3'b000));

endmodule

bind raid5_stripe_map r5_checker #(.W(W), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .dsk_wr_en(dsk_wr_en),
  .dsk_wr_d0(dsk_wr_d0),
  .dsk_wr_d1(dsk_wr_d1),
  .dsk_wr_d2(dsk_wr_d2),
  .rd_req   (rd_req),
  .rd_ready (rd_ready),
  .dsk_rd_en(dsk_rd_en),
  .rd_valid (rd_valid),
  .array_err(array_err),
  .wr_cnt   (wr_cnt),
  .wr_phase (wr_phase)
);

// File: tb/sim_raid5_stripe_map.sv
`timescale 1ns/1ps
module sim_raid5_stripe_map;
  localparam int W  = 32;
  localparam int SW = 16;
  localparam int NW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          wr_ready;
  logic          dsk_wr_en;
  logic [SW-1:0] dsk_wr_addr;
  logic [W-1:0]  dsk_wr_d0, dsk_wr_d1, dsk_wr_d2;
  logic          rd_req = 1'b0;
  logic [SW:0]   rd_addr = '0;
  logic          rd_ready;
  logic [2:0]    dsk_rd_en;
  logic [SW-1:0] dsk_rd_addr;
  logic [W-1:0]  q0 = '0, q1 = '0, q2 = '0;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic          rd_err;
  logic          fail_valid = 1'b0;
  logic [1:0]    fail_id = 2'd3;
  logic          array_err;

  always #2 clk = ~clk;

  raid5_stripe_map #(.W(W), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .dsk_wr_en(dsk_wr_en), .dsk_wr_addr(dsk_wr_addr),
    .dsk_wr_d0(dsk_wr_d0), .dsk_wr_d1(dsk_wr_d1), .dsk_wr_d2(dsk_wr_d2),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .dsk_rd_en(dsk_rd_en), .dsk_rd_addr(dsk_rd_addr),
    .dsk_rd_q0(q0), .dsk_rd_q1(q1), .dsk_rd_q2(q2),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .fail_valid(fail_valid), .fail_id(fail_id), .array_err(array_err)
  );

  // Disk model: 64 stripes, one-cycle read delay, a broken disk returns junk.
  logic [W-1:0] m0 [64];
  logic [W-1:0] m1 [64];
  logic [W-1:0] m2 [64];
  int bad_disk = 3;

  always @(posedge clk) begin
    if (dsk_wr_en) begin
      m0[dsk_wr_addr[5:0]] <= dsk_wr_d0;
      m1[dsk_wr_addr[5:0]] <= dsk_wr_d1;
      m2[dsk_wr_addr[5:0]] <= dsk_wr_d2;
    end
    if (dsk_rd_en[0]) q0 <= (bad_disk == 0) ? 32'hDEAD_BEEF : m0[dsk_rd_addr[5:0]];
    if (dsk_rd_en[1]) q1 <= (bad_disk == 1) ? 32'hDEAD_BEEF : m1[dsk_rd_addr[5:0]];
    if (dsk_rd_en[2]) q2 <= (bad_disk == 2) ? 32'hDEAD_BEEF : m2[dsk_rd_addr[5:0]];
  end

  logic [W-1:0] words [NW];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      wrap_up();
    end
  end

  // Disk expected to hold logical word k (bench restatement of R4/R5).
  function automatic int home_disk(input int k);
    int r = (k / 2) % 3;
    bit late = (k % 2) == 1;
    if (r == 0) return late ? 1 : 0;
    if (r == 1) return late ? 2 : 0;
    return late ? 1 : 2;
  endfunction

  task automatic push(input int k);
    logic [W-1:0] e0, e1, e2, a, b, p;
    wr_valid = 1'b1;
    wr_data  = words[k];
    @(negedge clk);
    if (k % 2 == 0) begin
      check(dsk_wr_en == 1'b0, "R2", "no write after first word", {31'd0, dsk_wr_en}, 0);
    end else begin
      a = words[k-1]; b = words[k]; p = a ^ b;
      case ((k / 2) % 3)
        0:       begin e0 = a; e1 = b; e2 = p; end
        1:       begin e0 = a; e1 = p; e2 = b; end
        default: begin e0 = p; e1 = b; e2 = a; end
      endcase
      check(dsk_wr_en === 1'b1 && dsk_wr_addr == SW'(k / 2), "R2", "stripe strobe/addr",
            {16'd0, dsk_wr_addr}, k / 2);
      check((dsk_wr_d0 ^ dsk_wr_d1 ^ dsk_wr_d2) == '0, "R3", "parity closes",
            dsk_wr_d0 ^ dsk_wr_d1 ^ dsk_wr_d2, 0);
      check(dsk_wr_d0 == e0 && dsk_wr_d1 == e1 && dsk_wr_d2 == e2, "R4", "rotation disk0",
            dsk_wr_d0, e0);
    end
  endtask

  // One read; checks enables, optional bubble, latency, data and error flag.
  task automatic rd(input int k, input int exp_lat, input int exp_en_cnt,
                    input logic [W-1:0] exp_d, input bit exp_err, input string req);
    int lat = 0;
    while (!rd_ready) @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = (SW+1)'(k);
    #0.5;
    check($countones(dsk_rd_en) == exp_en_cnt, req, "disk enables",
          {29'd0, dsk_rd_en}, exp_en_cnt);
    if (exp_en_cnt == 1)
      check(dsk_rd_en[home_disk(k)] == 1'b1, req, "enabled disk", {29'd0, dsk_rd_en}, home_disk(k));
    @(negedge clk);
    rd_req = 1'b0;
    lat = 1;
    if (exp_en_cnt == 2)
      check(rd_ready == 1'b0, "R7", "bubble after rebuild", {31'd0, rd_ready}, 0);
    while (!rd_valid && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, req, "latency", lat, exp_lat);
    check(rd_data == exp_d && rd_err == exp_err, req, "read data", rd_data, exp_d);
  endtask

  task automatic report_fail(input logic [1:0] id);
    fail_valid = 1'b1;
    fail_id    = id;
    @(negedge clk);
    fail_valid = 1'b0;
    fail_id    = 2'd3;
    @(negedge clk);
  endtask

  initial begin
    int k;
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) words[i] = $urandom;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(wr_ready && rd_ready && !rd_valid && !dsk_wr_en && dsk_rd_en == 3'b000 && !array_err,
          "R1", "reset outputs", {27'd0, wr_ready, rd_ready, rd_valid, dsk_wr_en, array_err}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NW; i++) push(i);
    wr_valid = 1'b0;
    @(negedge clk);

    // R5: random normal reads plus directed first/last words
    rd(0, 2, 1, words[0], 1'b0, "R5");
    rd(NW - 1, 2, 1, words[NW-1], 1'b0, "R5");
    for (int i = 0; i < 40; i++) begin
      k = $urandom_range(NW - 1);
      rd(k, 2, 1, words[k], 1'b0, "R5");
    end

    // R8: id 3 is ignored
    report_fail(2'd3);
    check(array_err == 1'b0, "R8", "id 3 ignored", {31'd0, array_err}, 0);
    rd(5, 2, 1, words[5], 1'b0, "R8");

    // R6: disk 1 fails
    report_fail(2'd1);
    bad_disk = 1;
    for (int i = 0; i < 6; i++)
      rd(i, (home_disk(i) == 1) ? 3 : 2, (home_disk(i) == 1) ? 2 : 1, words[i], 1'b0, "R6");
    for (int i = 0; i < 50; i++) begin
      k = $urandom_range(NW - 1);
      rd(k, (home_disk(k) == 1) ? 3 : 2, (home_disk(k) == 1) ? 2 : 1, words[k], 1'b0, "R6");
    end

    // R8: repeating the same disk is harmless
    report_fail(2'd1);
    check(array_err == 1'b0, "R8", "repeat id no error", {31'd0, array_err}, 0);
    rd(1, 3, 2, words[1], 1'b0, "R8");

    // R9: a second disk fails
    report_fail(2'd2);
    check(array_err == 1'b1 && wr_ready == 1'b0, "R9", "double failure",
          {30'd0, array_err, wr_ready}, 2'b10);
    rd(2, 2, 0, '0, 1'b1, "R9");
    rd(1, 2, 0, '0, 1'b1, "R9");
    repeat (3) @(negedge clk);
    check(array_err == 1'b1, "R9", "error sticky", {31'd0, array_err}, 1);

    // R1: reset clears the error
    rst_n = 1'b0;
    bad_disk = 3;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(array_err == 1'b0 && wr_ready == 1'b1, "R1", "error cleared by reset",
          {31'd0, array_err}, 0);
    rd(9, 2, 1, words[9], 1'b0, "R5");

    wrap_up();
  end

endmodule